// File: doc/BRIEF.md
# Error-Feedback First-Order Smoother

This block is a single-pole low-pass smoother for a stream of signed integer samples. Each accepted sample moves the held output toward itself by one A-th of the gap between them. A is fixed at build time as a power of two, A = 2^K, so the division is an arithmetic shift.

The fractional part that the shift discards is not thrown away. It is kept in a small remainder register and added into the error of the next update. A plain truncating smoother can stall a few codes short of a constant input, because the gap becomes smaller than A and the quotient becomes zero. Here the carried remainder grows until it crosses A, so the output always reaches the input exactly. This is done without biasing the rounding away from zero.

A small two-state sequencer reports each update. It has two states. `ST_QUIET` means no update happened on the last edge. `ST_PUBLISH` means the output register was just rewritten. An accepted sample moves the sequencer to `ST_PUBLISH`. A cycle with no sample moves it to `ST_QUIET`. Reset forces `ST_QUIET`.

Top module: `ef_smoother`

## Requirements
- R1: A synchronous reset clears the output, the carried remainder and the output valid to zero. After reset, the first update behaves as if it starts from output 0 and remainder 0.
- R2: On an edge where `smp_vld` is high, the bench computes three values. First, error e = sample − output + remainder. Second, quotient q = floor(e / 2^K). Third, the new output = output + q. All values are two's complement, and `smp_data` and `avg_data` are signed.
- R3: The new carried remainder is e − q·2^K. It is always in the range 0 to 2^K − 1, and the next accepted sample uses it as described in R2.
- R4: `avg_vld` is high in the cycle right after each edge that accepted a sample, and low after every other edge.
- R5: When `smp_vld` is low, `smp_data` is ignored. The output and the remainder hold their values.
- R6: If a constant input is held, the output becomes exactly equal to it. This includes steps smaller than 2^K, where a truncating smoother would stall.
- R7: Each update leaves the output between its previous value and the accepted sample, both ends included. The output never overshoots and never wraps, even for full-scale positive and negative samples.
- R8: If an accepted sample equals the current output, the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe; the sample is accepted on this edge |
| smp_data | input | DW | Signed input sample |
| avg_vld | output | 1 | High for one cycle after each accepted sample |
| avg_data | output | DW | Signed smoothed output |

## Verification
The hardest case to reach is the dead band. Here the gap between the input and the output is smaller than 2^K, so every quotient is zero. Progress then comes only from the hidden remainder building up across several samples. The stimulus first settles the output on one value. It then applies constant inputs a few codes above and below that value, with and without idle gaps between samples. Through all of this, a behavioural integer model is compared with both outputs on every clock. Full-scale swings between the most positive and most negative samples check the widened error path.

// File: rtl/ef_pkg.sv
package ef_pkg;
    typedef enum logic [0:0] {
        ST_QUIET   = 1'b0,
        ST_PUBLISH = 1'b1
    } ef_state_e;
endpackage

// File: rtl/ef_err_calc.sv
// Combinational update path: error with remainder feedback, floor quotient,
// and the new non-negative remainder.
module ef_err_calc #(
    parameter int DW = 16,
    parameter int K  = 4
) (
    input  logic signed [DW-1:0] sample,
    input  logic signed [DW-1:0] held,
    input  logic        [K-1:0]  rem,
    output logic signed [DW-1:0] held_next,
    output logic        [K-1:0]  rem_next
);
    localparam int EW = DW + 2;

    logic signed [EW-1:0] err;
    logic signed [DW-1:0] quot;

    always_comb begin
        err = EW'(sample) - EW'(held) + $signed({{(EW-K){1'b0}}, rem});
        // arithmetic shift gives floor division; magnitude fits DW bits
        quot      = DW'(err >>> K);
        rem_next  = err[K-1:0];
        held_next = held + quot;
    end
endmodule

// File: rtl/ef_hold_regs.sv
// Output and remainder registers, loaded only on an accepted sample.
module ef_hold_regs #(
    parameter int DW = 16,
    parameter int K  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [DW-1:0] held_next,
    input  logic        [K-1:0]  rem_next,
    output logic signed [DW-1:0] held_q,
    output logic        [K-1:0]  rem_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            held_q <= held_next;
            rem_q  <= rem_next;
        end
    end
endmodule

// File: rtl/ef_seq_ctrl.sv
// Two-state sequencer: ST_QUIET (no update last edge), ST_PUBLISH (update done).
module ef_seq_ctrl
    import ef_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smp_vld,
    output logic load,
    output logic avg_vld
);
    ef_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_QUIET;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET:   state_d = smp_vld ? ST_PUBLISH : ST_QUIET;
            ST_PUBLISH: state_d = smp_vld ? ST_PUBLISH : ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        load    = smp_vld;
        avg_vld = (state_q == ST_PUBLISH);
    end
endmodule

// File: rtl/ef_smoother.sv
module ef_smoother #(
    parameter int DW = 16,
    parameter int K  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    output logic          avg_vld,
    output logic [DW-1:0] avg_data
);
    logic                 load;
    logic signed [DW-1:0] held_q;
    logic signed [DW-1:0] held_next;
    logic        [K-1:0]  rem_q;
    logic        [K-1:0]  rem_next;

    ef_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .load    (load),
        .avg_vld (avg_vld)
    );

    ef_err_calc #(.DW(DW), .K(K)) u_calc (
        .sample    ($signed(smp_data)),
        .held      (held_q),
        .rem       (rem_q),
        .held_next (held_next),
        .rem_next  (rem_next)
    );

    ef_hold_regs #(.DW(DW), .K(K)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .held_next (held_next),
        .rem_next  (rem_next),
        .held_q    (held_q),
        .rem_q     (rem_q)
    );

    assign avg_data = held_q;
endmodule

// File: rtl/ef_smoother_chk.sv
module ef_smoother_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_vld,
    input logic signed [DW-1:0] smp_data,
    input logic                 avg_vld,
    input logic signed [DW-1:0] avg_data
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (avg_data == '0 && !avg_vld));                          // R1

    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> avg_vld);                                            // R4

    AST_VALID_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !avg_vld);                                          // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(avg_data));                                 // R5

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> ((avg_data >= $past(avg_data) && avg_data <= $past(smp_data)) ||
                     (avg_data <= $past(avg_data) && avg_data >= $past(smp_data)))); // R7

    AST_EQUAL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && smp_data == avg_data) |=> avg_data == $past(avg_data)); // R8
endmodule

bind ef_smoother ef_smoother_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_data ($signed(smp_data)),
    .avg_vld  (avg_vld),
    .avg_data ($signed(avg_data))
);

// File: tb/tb_ef_smoother.sv
module tb_ef_smoother;
    localparam int DW = 16;
    localparam int K  = 4;
    localparam int A  = 1 << K;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          avg_vld;
    logic [DW-1:0] avg_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state (after the last edge)
    int m_out = 0;
    int m_rem = 0;
    bit m_vld = 1'b0;

    always #5 clk = ~clk;

    ef_smoother #(.DW(DW), .K(K)) dut (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .avg_vld  (avg_vld),
        .avg_data (avg_data)
    );

    task automatic compare(input string tag);
        checks++;
        if (avg_vld !== m_vld) begin
            fails++;
            $display("FAIL %s R4 avg_vld actual=%0b expected=%0b", tag, avg_vld, m_vld);
        end
        checks++;
        if ($signed(avg_data) !== m_out) begin
            fails++;
            $display("FAIL %s R2 avg_data actual=%0d expected=%0d", tag, $signed(avg_data), m_out);
        end
    endtask

    // compare at the falling edge, then drive the next cycle and advance the model
    task automatic cyc(input bit r, input bit v, input int d, input string tag);
        int err;
        int q;
        @(negedge clk);
        compare(tag);
        rst      = r;
        smp_vld  = v;
        smp_data = DW'(d);
        if (r) begin
            m_out = 0; m_rem = 0; m_vld = 1'b0;
        end else if (v) begin
            err   = d - m_out + m_rem;
            q     = err >>> K;
            m_rem = err - q * A;
            m_out = m_out + q;
            m_vld = 1'b1;
        end else begin
            m_vld = 1'b0;
        end
    endtask

    task automatic expect_out(input int exp, input string tag);
        checks++;
        if ($signed(avg_data) !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, $signed(avg_data), exp);
        end
    endtask

    task automatic feed(input int d, input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, d, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 0, "R1 reset");
        cyc(1'b0, 1'b0, 0, "R1 idle");
        expect_out(0, "R1 out after reset");
        checks++;
        if (avg_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1 avg_vld actual=%0b expected=0", avg_vld);
        end

        // R6 dead band from zero: step smaller than A
        feed(5, 40, "R6 small step");
        cyc(1'b0, 1'b0, 0, "R6 settle");
        expect_out(5, "R6 small step reached");

        // R2 R6 large positive step
        feed(1000, 300, "R2 large step");
        cyc(1'b0, 1'b0, 0, "R6 settle");
        expect_out(1000, "R6 large step reached");

        // R8 equal sample keeps output
        feed(1000, 5, "R8 equal");
        cyc(1'b0, 1'b0, 0, "R8 settle");
        expect_out(1000, "R8 equal held");

        // R5 idle cycles with garbage data
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, -12345 + i * 999, "R5 ignore");
        expect_out(1000, "R5 held after idle");

        // R3 R6 dead band below with gaps
        for (int i = 0; i < 60; i++) cyc(1'b0, (i % 3) != 1, 993, "R3 gapped small step");
        cyc(1'b0, 1'b0, 0, "R6 settle");
        expect_out(993, "R6 gapped small step reached");

        // R7 full-scale swings and negative constant
        feed(32767, 400, "R7 max");
        cyc(1'b0, 1'b0, 0, "R7 settle");
        expect_out(32767, "R7 reached max");
        feed(-32768, 400, "R7 min");
        cyc(1'b0, 1'b0, 0, "R7 settle");
        expect_out(-32768, "R7 reached min");
        feed(-777, 400, "R6 negative");
        cyc(1'b0, 1'b0, 0, "R6 settle");
        expect_out(-777, "R6 negative reached");

        // R3 build a nonzero remainder, then R1 reset mid-stream
        feed(-770, 3, "R3 partial");
        cyc(1'b1, 1'b0, 0, "R1 mid reset");
        cyc(1'b0, 1'b0, 0, "R1 idle");
        expect_out(0, "R1 cleared mid-stream");
        feed(3, 30, "R1 fresh remainder");
        cyc(1'b0, 1'b0, 0, "R1 settle");
        expect_out(3, "R1 fresh small step");

        // R2 R4 random samples and strobes
        for (int i = 0; i < 3000; i++)
            cyc(1'b0, ($urandom % 4) != 0, int'($signed(16'($urandom))), "R2 random");
        for (int i = 0; i < 500; i++)
            cyc(1'b0, $urandom % 2 == 1, 200 + int'($urandom % 9) - 4, "R3 random near");

        cyc(1'b0, 1'b0, 0, "final");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule